// File: doc/BRIEF.md
# Buffered Page Program Engine for Serial NOR Flash

This block programs serial NOR flash over a single-line SPI link. Software loads a program opcode, a three- or four-byte flash address and the data through a word-wide register port. It then sets a start bit. The engine produces the whole frame on chip select, clock and data-out: the opcode, the address with its most significant byte first, then the data. Every byte goes out most significant bit first, in SPI mode 0.

Two data paths are available, and a buffer-enable bit picks one. With the buffer on, a 32-word page store supplies 128 data bytes. Each 32-bit word pushed to the page port carries four consecutive bytes, the lowest address in bits 7:0. With the buffer off, the frame carries exactly one data byte taken from a byte register. A change to the buffer-enable bit takes effect only when the engine is idle. Software confirms the change by reading the bit back.

The engine does not issue write-enable commands and does not poll flash status. Two guard bits must be set to declare both functions disabled before a program may start. The start bit reads back as 1 while a frame is on the wire and clears itself when the frame ends.

Top module: `bpp_engine`

## Requirements
- R1: After reset every register reads 0, chip select is high and the SPI clock is low. The SPI clock stays low whenever chip select is high.
- R2: A frame is the opcode (register 1), then the address most significant byte first, then the data bytes. Each byte goes out most significant bit first, with data stable on the rising SPI clock edge (mode 0). When bit 4 of the bus config register (address 6) is clear, the address is three bytes: byte registers 4, 3, 2, in that order.
- R3: When bus config bit 4 is set, the address is four bytes and the extra byte register (address 5) goes out first.
- R4: With the buffer enabled, a frame carries exactly 128 data bytes. Data byte 4k+j is bits 8j+7:8j of the k-th word pushed to the page port (address 10).
- R5: In buffered mode, data bytes beyond the words loaded so far are sent as 0xFF. Pushes after 32 words are ignored.
- R6: With the buffer disabled, a frame carries exactly one data byte, taken from the write data register (address 9).
- R7: Bit 0 of config register 2 (address 7) reads back the buffer mode in effect. A write to it is applied no earlier than the next cycle, and a change requested while a frame runs is held until that frame ends.
- R8: Writing 1 to bit 4 of the command register (address 0) starts a frame. The bit reads 1 while the frame runs and 0 once chip select has returned high. A start written during a frame is ignored.
- R9: A start is refused when bit 7 (write-enable issue disabled) or bit 5 (status polling disabled) of config register 3 (address 8) is clear. No frame is sent, and the command bit reads 0.
- R10: Page-port pushes made while a frame runs, including in its final cycle, are ignored. The page store is emptied when a frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
Two functions can fall in the same cycle: the end of a frame, which empties the page store and releases the buffer mode, and software actions that reach the page store or the mode bit. The bench pushes a marker word on every cycle of a buffered frame, up to and including the cycle in which chip select rises. It then runs a frame with no new pushes and requires all 128 data bytes to be 0xFF. In a second case, the buffer-enable bit is cleared in the middle of a frame. The bench requires the readback to hold the old value until the frame has ended, and the next frame to carry exactly one data byte.

// File: rtl/bpp_pkg.sv
// Shared register addresses and configuration type for the page program engine.
package bpp_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CMD    = 4'd0;
    localparam logic [REG_AW-1:0] A_OPC    = 4'd1;
    localparam logic [REG_AW-1:0] A_ADR0   = 4'd2;
    localparam logic [REG_AW-1:0] A_ADR1   = 4'd3;
    localparam logic [REG_AW-1:0] A_ADR2   = 4'd4;
    localparam logic [REG_AW-1:0] A_ADR3   = 4'd5;
    localparam logic [REG_AW-1:0] A_BUS    = 4'd6;
    localparam logic [REG_AW-1:0] A_CFG2   = 4'd7;
    localparam logic [REG_AW-1:0] A_CFG3   = 4'd8;
    localparam logic [REG_AW-1:0] A_WDATA  = 4'd9;
    localparam logic [REG_AW-1:0] A_PAGE   = 4'd10;

    localparam int BIT_START   = 4;
    localparam int BIT_ADDR4   = 4;
    localparam int BIT_BUFEN   = 0;
    localparam int BIT_NO_WREN = 7;
    localparam int BIT_NO_POLL = 5;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] adr0;
        logic [7:0] adr1;
        logic [7:0] adr2;
        logic [7:0] adr3;
        logic       addr4;
        logic       no_wren;
        logic       no_poll;
        logic [7:0] wdata;
    } bpp_cfg_t;
endpackage

// File: rtl/bpp_regs.sv
// Register file of the page program engine.
// Decodes word writes, produces the start request and page-port pushes,
// and holds the buffer-mode bit with its deferred application.
// Assumes one register access per cycle; frame-shaping registers are
// frozen while a frame is running so the frame stays self-consistent.
module bpp_regs
    import bpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              launch,
    output bpp_cfg_t          cfg,
    output logic              wbuf_en,
    output logic              start_req,
    output logic              push,
    output logic [31:0]       push_data
);
    logic wbuf_req;
    logic frame_wr_ok;

    assign frame_wr_ok = reg_we && !busy;

    // Configuration registers; frame-shaping fields frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            wbuf_req <= 1'b0;
        end else begin
            if (frame_wr_ok) begin
                case (reg_addr)
                    A_OPC:   cfg.opcode <= reg_wdata[7:0];
                    A_ADR0:  cfg.adr0   <= reg_wdata[7:0];
                    A_ADR1:  cfg.adr1   <= reg_wdata[7:0];
                    A_ADR2:  cfg.adr2   <= reg_wdata[7:0];
                    A_ADR3:  cfg.adr3   <= reg_wdata[7:0];
                    A_BUS:   cfg.addr4  <= reg_wdata[BIT_ADDR4];
                    A_WDATA: cfg.wdata  <= reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (reg_we && reg_addr == A_CFG3) begin
                cfg.no_wren <= reg_wdata[BIT_NO_WREN];
                cfg.no_poll <= reg_wdata[BIT_NO_POLL];
            end
            if (reg_we && reg_addr == A_CFG2)
                wbuf_req <= reg_wdata[BIT_BUFEN];
        end
    end

    // Buffer mode in effect: follows the request only between frames.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wbuf_en <= 1'b0;
        else if (!busy && !launch)
            wbuf_en <= wbuf_req;
    end

    // Strobes towards the sequencer and the page store.
    always_comb begin
        start_req = reg_we && reg_addr == A_CMD && reg_wdata[BIT_START];
        push      = reg_we && reg_addr == A_PAGE;
        push_data = reg_wdata;
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CMD:   reg_rdata[BIT_START] = busy;
            A_OPC:   reg_rdata[7:0] = cfg.opcode;
            A_ADR0:  reg_rdata[7:0] = cfg.adr0;
            A_ADR1:  reg_rdata[7:0] = cfg.adr1;
            A_ADR2:  reg_rdata[7:0] = cfg.adr2;
            A_ADR3:  reg_rdata[7:0] = cfg.adr3;
            A_BUS:   reg_rdata[BIT_ADDR4] = cfg.addr4;
            A_CFG2:  reg_rdata[BIT_BUFEN] = wbuf_en;
            A_CFG3: begin
                reg_rdata[BIT_NO_WREN] = cfg.no_wren;
                reg_rdata[BIT_NO_POLL] = cfg.no_poll;
            end
            A_WDATA: reg_rdata[7:0] = cfg.wdata;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bpp_page_buf.sv
// Page store: WORDS little-endian 32-bit words, read out one byte at a time.
// Bytes past the filled words read as 0xFF. Pushes beyond WORDS are dropped.
// Assumes the caller gates pushes while a frame is running.
module bpp_page_buf #(
    parameter int WORDS  = 32,
    localparam int BYTES  = WORDS * 4,
    localparam int BIDX_W = $clog2(BYTES),
    localparam int WIDX_W = BIDX_W - 2,
    localparam int FILL_W = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [31:0]       push_data,
    input  logic              clear,
    input  logic [BIDX_W-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    output logic [FILL_W-1:0] fill
);
    logic [31:0]       mem [WORDS];
    logic [WIDX_W-1:0] widx;
    logic [1:0]        lane;

    // Fill counter: emptied at frame end, saturates at WORDS.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            fill <= '0;
        else if (push && fill != FILL_W'(WORDS))
            fill <= fill + 1'b1;
    end

    // Word storage, written at the fill position.
    always_ff @(posedge clk) begin
        if (push && fill != FILL_W'(WORDS) && !clear)
            mem[WIDX_W'(fill)] <= push_data;
    end

    // Byte read with 0xFF padding past the loaded words.
    always_comb begin
        widx = rd_idx[BIDX_W-1:2];
        lane = rd_idx[1:0];
        if (FILL_W'(widx) < fill)
            rd_byte = mem[widx][8*lane +: 8];
        else
            rd_byte = 8'hFF;
    end
endmodule

// File: rtl/bpp_shifter.sv
// Single-line SPI frame serializer, mode 0, MSB first.
// Requests bytes by index; the byte for byte_idx must be presented
// combinationally on byte_in. SCK half period is SCK_HALF clocks.
module bpp_shifter #(
    parameter int SCK_HALF = 2,
    parameter int IDX_W    = 8,
    localparam int DIV_W   = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [7:0]       byte_in,
    output logic [IDX_W-1:0] byte_idx,
    output logic             active,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi
);
    logic [DIV_W-1:0] div;
    logic [2:0]       bit_cnt;

    // Frame sequencing: clock phases, bit and byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            done     <= 1'b0;
            spi_cs_n <= 1'b1;
            spi_sck  <= 1'b0;
            div      <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    spi_cs_n <= 1'b0;
                    div      <= '0;
                    bit_cnt  <= '0;
                    byte_idx <= '0;
                end
            end else if (div == DIV_W'(SCK_HALF - 1)) begin
                div <= '0;
                if (!spi_sck) begin
                    spi_sck <= 1'b1;
                end else begin
                    spi_sck <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        bit_cnt <= '0;
                        if (byte_idx == last_idx) begin
                            active   <= 1'b0;
                            spi_cs_n <= 1'b1;
                            done     <= 1'b1;
                            byte_idx <= '0;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    // Data out: current bit of the requested byte, MSB first.
    assign spi_mosi = active ? byte_in[~bit_cnt] : 1'b0;
endmodule

// File: rtl/bpp_engine.sv
// Buffered page program engine: top level.
// Accepts register accesses, gates the start on the two guard bits,
// builds the frame byte stream (opcode, address MSB first, data) and
// drives it out through the serializer. Exactly one program runs at a time.
module bpp_engine
    import bpp_pkg::*;
#(
    parameter int PAGE_WORDS = 32,
    parameter int SCK_HALF   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi
);
    localparam int PAGE_BYTES = PAGE_WORDS * 4;
    localparam int BIDX_W     = $clog2(PAGE_BYTES);
    localparam int FILL_W     = $clog2(PAGE_WORDS + 1);
    localparam int IDX_W      = $clog2(PAGE_BYTES + 6);

    bpp_cfg_t          cfg;
    logic              wbuf_en;
    logic              start_req;
    logic              push;
    logic [31:0]       push_data;
    logic              busy;
    logic              done;
    logic              launch;
    logic              no_wren;
    logic              no_poll;
    logic [IDX_W-1:0]  byte_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  alen;
    logic [IDX_W-1:0]  data_idx;
    logic [7:0]        byte_in;
    logic [7:0]        page_byte;
    logic [FILL_W-1:0] fill;

    assign no_wren = cfg.no_wren;
    assign no_poll = cfg.no_poll;

    bpp_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .launch    (launch),
        .cfg       (cfg),
        .wbuf_en   (wbuf_en),
        .start_req (start_req),
        .push      (push),
        .push_data (push_data)
    );

    // Start gating: idle engine and both guard bits set.
    assign launch = start_req && !busy && cfg.no_wren && cfg.no_poll;

    // Frame geometry: address length and index of the last byte.
    always_comb begin
        alen     = cfg.addr4 ? IDX_W'(4) : IDX_W'(3);
        last_idx = alen + (wbuf_en ? IDX_W'(PAGE_BYTES) : IDX_W'(1));
        data_idx = byte_idx - alen - IDX_W'(1);
    end

    bpp_page_buf #(
        .WORDS (PAGE_WORDS)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push && !busy),
        .push_data (push_data),
        .clear     (done),
        .rd_idx    (data_idx[BIDX_W-1:0]),
        .rd_byte   (page_byte),
        .fill      (fill)
    );

    // Byte source select for the current frame position.
    always_comb begin
        if (byte_idx == '0) begin
            byte_in = cfg.opcode;
        end else if (byte_idx <= alen) begin
            case (byte_idx + (cfg.addr4 ? IDX_W'(0) : IDX_W'(1)))
                IDX_W'(1): byte_in = cfg.adr3;
                IDX_W'(2): byte_in = cfg.adr2;
                IDX_W'(3): byte_in = cfg.adr1;
                default:   byte_in = cfg.adr0;
            endcase
        end else begin
            byte_in = wbuf_en ? page_byte : cfg.wdata;
        end
    end

    bpp_shifter #(
        .SCK_HALF (SCK_HALF),
        .IDX_W    (IDX_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .last_idx (last_idx),
        .byte_in  (byte_in),
        .byte_idx (byte_idx),
        .active   (busy),
        .done     (done),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi)
    );
endmodule

// File: rtl/bpp_engine_chk.sv
// Property checker for the page program engine, bound to the top level.
module bpp_engine_chk #(
    parameter int FILL_W = 6,
    parameter int WORDS  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_sck,
    input logic              busy,
    input logic              wbuf_en,
    input logic [FILL_W-1:0] fill,
    input logic              no_wren,
    input logic              no_poll
);
    // R1
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R8
    cs_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R7
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wbuf_en));

    // R9
    guarded_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(no_wren && no_poll));

    // R10
    fill_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fill));

    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(WORDS));
endmodule

bind bpp_engine bpp_engine_chk #(.FILL_W(FILL_W), .WORDS(PAGE_WORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .busy     (busy),
    .wbuf_en  (wbuf_en),
    .fill     (fill),
    .no_wren  (no_wren),
    .no_poll  (no_poll)
);

// File: tb/tb_bpp_engine.sv
module tb_bpp_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bpp_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    // SPI monitor: sample data on rising clock while selected
    logic [7:0] mon_b [0:255];
    int mon_n = 0, mon_bits = 0, frames = 0;
    logic [7:0] mon_sh = '0;
    always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
        mon_sh = {mon_sh[6:0], spi_mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            if (mon_n < 256) mon_b[mon_n] = mon_sh;
            mon_n++;
            mon_bits = 0;
        end
    end
    always @(posedge spi_cs_n) frames++;

    logic [7:0]  exp_b [0:255];
    int          exp_n;
    logic [31:0] pw [0:63];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_we = 1'b0; reg_addr = a; #1 d = reg_rdata;
    endtask

    // Expected frame from the requirements: R2/R3 header, R4/R5/R6 data
    task automatic build(input logic [7:0] opc, input logic [31:0] adr, input bit four,
                         input bit buffered, input int nwords, input logic [7:0] wd);
        exp_n = 0;
        exp_b[exp_n++] = opc;
        if (four) exp_b[exp_n++] = adr[31:24];
        exp_b[exp_n++] = adr[23:16];
        exp_b[exp_n++] = adr[15:8];
        exp_b[exp_n++] = adr[7:0];
        if (buffered) begin
            for (int i = 0; i < 128; i++) begin
                int w = i / 4;
                exp_b[exp_n++] = (w < nwords && w < 32) ? pw[w][8*(i%4) +: 8] : 8'hFF;
            end
        end else begin
            exp_b[exp_n++] = wd;
        end
    endtask

    task automatic setup(input logic [7:0] opc, input logic [31:0] adr, input bit four, input logic [7:0] wd);
        wr(4'd1, {24'd0, opc});
        wr(4'd2, {24'd0, adr[7:0]});
        wr(4'd3, {24'd0, adr[15:8]});
        wr(4'd4, {24'd0, adr[23:16]});
        wr(4'd5, {24'd0, adr[31:24]});
        wr(4'd6, {27'd0, four, 4'd0});
        wr(4'd9, {24'd0, wd});
    endtask

    task automatic wait_frame(input int f0);
        int t = 0;
        while (frames == f0 && t < 20000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_frame(input string tag);
        int bad = -1;
        if (mon_n != exp_n) begin
            chk(0, {tag, " length"}, mon_n, exp_n);
        end else begin
            for (int i = 0; i < exp_n; i++) if (bad < 0 && mon_b[i] !== exp_b[i]) bad = i;
            if (bad >= 0) chk(0, {tag, " byte"}, int'(mon_b[bad]), int'(exp_b[bad]));
            else chk(1, tag, 0, 0);
        end
    endtask

    task automatic run(input string tag);
        int f0 = frames;
        logic [31:0] r;
        mon_n = 0; mon_bits = 0;
        wr(4'd0, 32'h10);
        rd(4'd0, r);
        chk(r[4] == 1'b1, "R8 busy readback", r, 32'h10);
        wait_frame(f0);
        rd(4'd0, r);
        chk(r == 0, "R8 self clear", r, 0);
        cmp_frame(tag);
    endtask

    task automatic set_buf(input bit en);
        logic [31:0] r;
        int t = 0;
        wr(4'd7, {31'd0, en});
        rd(4'd7, r);
        while (r[0] !== en && t < 100) begin rd(4'd7, r); t++; end
        chk(r[0] == en, "R7 enable readback", r, en);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int f0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], r);
            chk(r == 0, "R1 reset register", r, 0);
        end
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 idle pins", {spi_cs_n, spi_sck}, 2);

        // R9: guard bits clear or partly set refuse the start
        setup(8'h02, 32'h00123456, 0, 8'h5A);
        for (int g = 0; g < 2; g++) begin
            f0 = frames;
            wr(4'd8, g == 0 ? 32'h0 : 32'h80);
            wr(4'd0, 32'h10);
            rd(4'd0, r);
            chk(r == 0, "R9 refused start cmd", r, 0);
            repeat (60) @(negedge clk);
            chk(frames == f0, "R9 no frame", frames - f0, 0);
        end
        wr(4'd8, 32'hA0);

        // R2, R6: three-byte address, single byte
        build(8'h02, 32'h00123456, 0, 0, 0, 8'h5A);
        run("R2 R6 unbuffered 3B");
        // R3: four-byte address
        setup(8'h12, 32'hA1B2C3D4, 1, 8'hC3);
        build(8'h12, 32'hA1B2C3D4, 1, 0, 0, 8'hC3);
        run("R3 unbuffered 4B");

        // R4: buffered, random contents and address modes
        set_buf(1);
        for (int k = 0; k < 3; k++) begin
            logic [31:0] adr = $urandom;
            bit four = $urandom_range(0, 1);
            setup(8'h02, adr, four, 8'h00);
            for (int w = 0; w < 32; w++) begin pw[w] = $urandom; wr(4'd10, pw[w]); end
            build(8'h02, adr, four, 1, 32, 8'h00);
            run("R4 buffered page");
        end

        // R5: partial fill padded, overfill dropped
        setup(8'h02, 32'h00000100, 0, 8'h00);
        for (int w = 0; w < 5; w++) begin pw[w] = $urandom; wr(4'd10, pw[w]); end
        build(8'h02, 32'h00000100, 0, 1, 5, 8'h00);
        run("R5 partial fill");
        for (int w = 0; w < 40; w++) begin pw[w] = $urandom; wr(4'd10, pw[w]); end
        build(8'h02, 32'h00000100, 0, 1, 32, 8'h00);
        run("R5 overfill");

        // R10, R8: pushes throughout the frame incl. final cycle; restart ignored
        for (int w = 0; w < 32; w++) begin pw[w] = w * 32'h01010101; wr(4'd10, pw[w]); end
        f0 = frames; mon_n = 0; mon_bits = 0;
        wr(4'd0, 32'h10);
        wr(4'd0, 32'h10);
        while (frames == f0) begin
            @(negedge clk); reg_we = 1'b1; reg_addr = 4'd10; reg_wdata = 32'hDEADBEEF;
        end
        @(negedge clk); reg_we = 1'b0;
        build(8'h02, 32'h00000100, 0, 1, 32, 8'h00);
        cmp_frame("R10 frame with pushes");
        repeat (200) @(negedge clk);
        chk(frames == f0 + 1, "R8 restart ignored", frames - f0, 1);
        build(8'h02, 32'h00000100, 0, 1, 0, 8'h00);
        run("R10 emptied store");

        // R7: mode change during a frame is deferred
        f0 = frames; mon_n = 0; mon_bits = 0;
        wr(4'd0, 32'h10);
        wr(4'd7, 32'h0);
        repeat (3) @(negedge clk);
        rd(4'd7, r);
        chk(r[0] == 1'b1, "R7 deferred while busy", r, 1);
        wait_frame(f0);
        rd(4'd7, r);
        chk(r[0] == 1'b0, "R7 applied after frame", r, 0);
        setup(8'h02, 32'h00ABCDEF, 0, 8'h3C);
        build(8'h02, 32'h00ABCDEF, 0, 0, 0, 8'h3C);
        run("R6 R7 back to single byte");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule